// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects requests from a set of peripheral sources and hands the CPU one source index at a time. Each source owns an 8-bit control register with three fields: a pending flag, a mask that holds a request back, and a 3-bit priority level. Peripherals raise the pending flag with a one-cycle pulse. Software can read and write any register as a whole byte, or one bit at a time by giving a bit index.

Among the sources that are both pending and unmasked, the controller picks the one with the best level. Level code 0 is the most urgent. When several sources share that level, the lowest index wins. The chosen index goes to the CPU over a valid/ready handshake:
- `irq_valid` is high while an eligible source exists.
- While `irq_ready` is low, `irq_id` is held and does not change.
- A cycle with `irq_valid && irq_ready` is the acknowledge. It clears that source's flag.
- In the same edge, the next choice is loaded.

A source that is presented but has not been acknowledged is not displaced by a later, more urgent request. It is replaced only when it stops being eligible.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every control register reads 0x47 (flag 0, mask 1, level 7) and `irq_valid` is low.
- R2: Byte layout: bit 7 is the pending flag, bit 6 is the mask, bits 2:0 are the level. Bits 5:3 always read 0, and writes to them have no effect. A byte access (`bus_bit`=0) reads or writes the whole register.
- R3: A bit access (`bus_bit`=1) selects bit `bus_bitsel` of the addressed register.
  - A bit write stores `bus_wdata[0]` into that bit only.
  - A bit read returns that bit on `bus_rdata[0]`, with all other read bits at 0.
  - Bit writes to indices 5..3 have no effect.
- R4: A source with mask 1 is never presented, and its pending flag stays set. Clearing the mask makes it eligible.
- R5: Among eligible sources, the one with the numerically smallest level code is chosen.
- R6: When eligible sources tie on the best level, the lowest index is chosen.
- R7: After each clock edge, `irq_valid` is 1 exactly when at least one source is pending and unmasked. A change in the flags shows up on `irq_valid`/`irq_id` at the same edge that updates the register.
- R8: While `irq_valid` is high and `irq_ready` is low, `irq_id` stays unchanged as long as that source remains eligible, even if a more urgent source arrives.
- R9: A cycle with `irq_valid && irq_ready` clears the flag of source `irq_id`. In the same edge the controller presents the best remaining eligible source.
- R10: A `src_req` pulse sets the flag even when, in the same cycle, an acknowledge clears that source or software writes its flag to 0.
- R11: Software writing the flag bit to 1 raises a request, and writing it to 0 cancels a pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_bit | input | 1 | 1 = single-bit access, 0 = byte access |
| bus_addr | input | AW | Source register index |
| bus_bitsel | input | 3 | Bit index for single-bit access |
| bus_wdata | input | 8 | Write byte (bit access uses bit 0) |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| src_req | input | NUM_SRC | One-cycle request pulses, one per source |
| irq_valid | output | 1 | An eligible source is presented |
| irq_ready | input | 1 | CPU accepts the presented source |
| irq_id | output | IW | Index of the presented source |

## Verification
The bench sweeps many pseudo-random mixes of levels, masks and flags across all eight sources. It checks the chosen index against a winner computed in the bench, then acknowledges and checks the runner-up:
- A wrong compare direction would pick the least urgent source.
- A tie broken toward high indices would pick the wrong source on equal levels.
- An arbiter fed the old flags would present the source that was just acknowledged a second time.

Directed cases cover the remaining corners:
- A request pulse colliding with an acknowledge, or with a software clear; letting the clear win loses an interrupt.
- A more urgent arrival while the CPU stalls; switching the presented index breaks the handshake.
- Bit writes that must leave neighbouring bits untouched.
- Reserved bits that must read zero.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int CTL_W    = 8;
  localparam int LVL_W    = 3;
  localparam int FLAG_POS = 7;
  localparam int MASK_POS = 6;
  localparam logic [CTL_W-1:0] CTL_RESET = 8'h47;

  typedef struct packed {
    logic             flag;
    logic             mask;
    logic [LVL_W-1:0] lvl;
  } ctl_t;

  function automatic logic [CTL_W-1:0] ctl_pack(ctl_t c);
    return {c.flag, c.mask, 3'b000, c.lvl};
  endfunction

  function automatic ctl_t ctl_unpack(logic [CTL_W-1:0] b);
    ctl_t c;
    c.flag = b[FLAG_POS];
    c.mask = b[MASK_POS];
    c.lvl  = b[LVL_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/irqc_src_reg.sv
module irqc_src_reg
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_byte,
  input  logic             wr_bit,
  input  logic [2:0]       bitsel,
  input  logic [CTL_W-1:0] wdata,
  input  logic             hw_set,
  input  logic             ack_clr,
  output ctl_t             ctl_q,
  output ctl_t             ctl_d
);
  logic sw_flag_wr;

  assign sw_flag_wr = wr_byte || (wr_bit && bitsel == 3'(FLAG_POS));

  always_comb begin
    ctl_d = ctl_q;
    if (wr_byte) begin
      ctl_d = ctl_unpack(wdata);
    end else if (wr_bit) begin
      case (bitsel)
        3'd7:    ctl_d.flag   = wdata[0];
        3'd6:    ctl_d.mask   = wdata[0];
        3'd2:    ctl_d.lvl[2] = wdata[0];
        3'd1:    ctl_d.lvl[1] = wdata[0];
        3'd0:    ctl_d.lvl[0] = wdata[0];
        default: ;
      endcase
    end
    if (ack_clr && !sw_flag_wr) ctl_d.flag = 1'b0;
    if (hw_set)                 ctl_d.flag = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= ctl_unpack(CTL_RESET);
    else        ctl_q <= ctl_d;
  end

  // R10: a hardware pulse always leaves the flag set
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> ctl_q.flag);
  // R9: an acknowledge with no competing set or write clears the flag
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr && !hw_set && !sw_flag_wr) |=> !ctl_q.flag);
  // R4: a pending flag survives regardless of mask until cleared
  a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.flag && !ack_clr && !sw_flag_wr) |=> ctl_q.flag);
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  localparam int IW     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]            elig,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
  output logic                          any,
  output logic [IW-1:0]                 idx
);
  logic [LVL_W:0] best;

  always_comb begin
    best = {1'b1, {LVL_W{1'b0}}};
    any  = 1'b0;
    idx  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && ({1'b0, lvl[i]} < best)) begin
        best = {1'b0, lvl[i]};
        idx  = IW'(i);
        any  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int AW     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int IW     = AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic               bus_bit,
  input  logic [AW-1:0]      bus_addr,
  input  logic [2:0]         bus_bitsel,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic [NUM_SRC-1:0] src_req,
  output logic               irq_valid,
  input  logic               irq_ready,
  output logic [IW-1:0]      irq_id
);
  ctl_t [NUM_SRC-1:0]            ctl_q, ctl_d;
  logic [NUM_SRC-1:0]            elig_q, elig_d;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_d;
  logic                          ack, any_d, reload;
  logic [IW-1:0]                 idx_d;
  logic [CTL_W-1:0]              rd_byte;

  assign ack = irq_valid && irq_ready;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic sel;
    assign sel = bus_en && bus_we && (bus_addr == AW'(i));
    irqc_src_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_byte (sel && !bus_bit),
      .wr_bit  (sel && bus_bit),
      .bitsel  (bus_bitsel),
      .wdata   (bus_wdata),
      .hw_set  (src_req[i]),
      .ack_clr (ack && (irq_id == IW'(i))),
      .ctl_q   (ctl_q[i]),
      .ctl_d   (ctl_d[i])
    );
    assign elig_q[i] = ctl_q[i].flag && !ctl_q[i].mask;
    assign elig_d[i] = ctl_d[i].flag && !ctl_d[i].mask;
    assign lvl_d[i]  = ctl_d[i].lvl;
  end

  irqc_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_arb (
    .elig (elig_d),
    .lvl  (lvl_d),
    .any  (any_d),
    .idx  (idx_d)
  );

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (bus_addr == AW'(i)) rd_byte = ctl_pack(ctl_q[i]);
    if (bus_bit) bus_rdata = {7'b0, rd_byte[bus_bitsel]};
    else         bus_rdata = rd_byte;
  end

  assign reload = !irq_valid || irq_ready || !elig_d[irq_id];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_id    <= '0;
    end else if (reload) begin
      irq_valid <= any_d;
      irq_id    <= idx_d;
    end
  end

  // R7: the presented request mirrors the eligible set in the registers
  a_r7_valid_matches: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid == (|elig_q));
  // R4: only a pending, unmasked source is ever presented
  a_r4_presented_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> elig_q[irq_id]);
  // R8: a stalled, still eligible choice is held
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready && elig_d[irq_id]) |=> ($stable(irq_id) && irq_valid));
  // R2: reserved bits read as zero on byte reads
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_bit |-> (bus_rdata[5:3] == 3'b000));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 0, bus_we = 0, bus_bit = 0;
  logic [2:0] bus_addr = '0, bus_bitsel = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] src_req = '0;
  logic irq_valid, irq_ready = 1'b0;
  logic [2:0] irq_id;
  int errors = 0, checks = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(N)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_bit(bus_bit),
    .bus_addr(bus_addr), .bus_bitsel(bus_bitsel), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_req(src_req), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_id(irq_id));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(int a, int d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_bit = 0; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic wr_bit(int a, int b, int v);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_bit = 1; bus_addr = 3'(a); bus_bitsel = 3'(b);
    bus_wdata = 8'(v);
    @(negedge clk);
    bus_en = 0; bus_we = 0; bus_bit = 0;
  endtask

  task automatic rd(int a, int bitmode, int b, output int d);
    bus_en = 1; bus_we = 0; bus_bit = bitmode[0]; bus_addr = 3'(a); bus_bitsel = 3'(b);
    #1 d = int'(bus_rdata);
    bus_en = 0; bus_bit = 0;
  endtask

  task automatic ack_once();
    @(negedge clk); irq_ready = 1;
    @(negedge clk); irq_ready = 0;
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  function automatic int winner(logic [N-1:0] f, logic [N-1:0] m, logic [N-1:0][2:0] l);
    int best = 8, w = -1;
    for (int i = 0; i < N; i++)
      if (f[i] && !m[i] && int'(l[i]) < best) begin best = int'(l[i]); w = i; end
    return w;
  endfunction

  initial begin
    #200000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int d, w;
    logic [N-1:0] f, m;
    logic [N-1:0][2:0] l;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < N; i++) begin rd(i, 0, 0, d); check("R1 reset value", d, 'h47); end
    check("R1 valid low", int'(irq_valid), 0);
    // R2 reserved bits
    wr_byte(0, 'h3F); rd(0, 0, 0, d); check("R2 reserved ignored", d, 'h07);
    wr_byte(0, 'h47);
    // R3 bit accesses
    wr_bit(4, 6, 0); rd(4, 0, 0, d); check("R3 bit write mask only", d, 'h07);
    wr_bit(4, 1, 0); rd(4, 0, 0, d); check("R3 bit write level bit", d, 'h05);
    wr_bit(4, 4, 1); rd(4, 0, 0, d); check("R3 reserved bit write", d, 'h05);
    rd(4, 1, 2, d); check("R3 bit read", d, 1);
    rd(4, 1, 1, d); check("R3 bit read zero", d, 0);
    wr_byte(4, 'h47);
    // R4 mask holds request
    wr_byte(5, 'hC0); check("R4 masked not presented", int'(irq_valid), 0);
    rd(5, 0, 0, d); check("R4 flag kept while masked", d, 'hC0);
    wr_bit(5, 6, 0); check("R4 unmask presents", int'(irq_valid), 1);
    check("R4 unmask id", int'(irq_id), 5);
    wr_byte(5, 'h47); check("R11 software cancel", int'(irq_valid), 0);
    // R8 hold under stall, R9 ack hands over
    wr_byte(3, 'h85); check("R7 valid on write", int'(irq_valid), 1);
    wr_byte(1, 'h80); check("R8 id held", int'(irq_id), 3);
    ack_once(); check("R9 next after ack", int'(irq_id), 1);
    rd(3, 0, 0, d); check("R9 acked flag cleared", d, 'h05);
    ack_once(); check("R9 none left", int'(irq_valid), 0);
    // R10 set beats ack and software clear
    wr_byte(2, 'h02);
    @(negedge clk); src_req[2] = 1;
    @(negedge clk); src_req[2] = 0;
    check("R10 pulse presents", int'(irq_id), 2);
    @(negedge clk); src_req[2] = 1; irq_ready = 1;
    @(negedge clk); src_req[2] = 0; irq_ready = 0;
    rd(2, 0, 0, d); check("R10 set beats ack", d, 'h82);
    @(negedge clk); src_req[2] = 1; bus_en = 1; bus_we = 1; bus_addr = 2; bus_wdata = 'h02;
    @(negedge clk); src_req[2] = 0; bus_en = 0; bus_we = 0;
    rd(2, 0, 0, d); check("R10 set beats sw clear", d, 'h82);
    wr_byte(2, 'h02); check("R11 cancel clears valid", int'(irq_valid), 0);
    wr_bit(2, 7, 1); check("R11 software raise", int'(irq_valid), 1);
    wr_byte(2, 'h47);
    // R5 R6 sweep
    for (int it = 0; it < 60; it++) begin
      for (int i = 0; i < N; i++) begin
        l[i] = 3'(rnd() % 8);
        if (it % 4 == 0) l[i] = 3'(rnd() % 2);
        m[i] = rnd() % 2 == 0;
        f[i] = rnd() % 3 != 0;
      end
      for (int i = 0; i < N; i++) wr_byte(i, {f[i], 1'b1, 3'b000, l[i]});
      w = winner(f, m, l);
      if (w >= 0) wr_bit(w, 6, 0);
      for (int i = 0; i < N; i++) if (!m[i] && i != w) wr_bit(i, 6, 0);
      check("R7 sweep valid", int'(irq_valid), w >= 0 ? 1 : 0);
      if (w >= 0) begin
        check("R5 R6 sweep winner", int'(irq_id), w);
        ack_once();
        rd(w, 1, 7, d); check("R9 sweep flag cleared", d, 0);
        f[w] = 1'b0;
        w = winner(f, m, l);
        check("R9 sweep next valid", int'(irq_valid), w >= 0 ? 1 : 0);
        if (w >= 0) check("R5 R6 sweep runner-up", int'(irq_id), w);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule